// File: doc/BRIEF.md
# Flash write status bit generator

This block sits inside a byte-wide parallel NOR flash and produces the polling bit that a host reads while an internal program or erase runs. A single strobe starts each operation, standing in for the full command sequence. The start carries the target address and byte for a program, or a sector selection mask for an erase. A per-sector protect map decides which sectors may change. A done pulse from a simplified internal timer ends each unprotected operation. The block also keeps a small storage array, so every read returns either array data or array data with its top bit replaced by a status value.

During a program, a read of the target address shows the inverse of the top bit of the byte being written. Once the program completes, the same read shows the stored byte, so its top bit is true. During an erase, any read inside a selected sector shows a zero top bit. While the erase is suspended, that bit reads as one. A program issued during suspend follows the same inverse-then-true rule. If every target is protected, the status stays up for a fixed window measured in clock cycles and then clears with nothing changed. The window is derived from `CLK_PER_US`, so a bench can shorten it. The top bit can turn true in a different cycle from the lower bits, and the lower bits may show stale array content while status is shown.

Top module: `flash_poll_status`

## Requirements
- R1: After reset `busy` is 0 and every array byte reads as all ones.
- R2: Between the start of an unprotected program and its done pulse, a read at the program address returns the old array byte with bit DATA_W-1 replaced by the inverse of bit DATA_W-1 of the byte being written.
- R3: A done pulse during a program stores old AND new into the target byte and ends the operation. Reads then return the stored byte, including the true top bit.
- R4: A program whose target sector is protected shows R2 status for exactly PROG_US*CLK_PER_US cycles after the strobe edge. The array is then unchanged and `busy` is 0.
- R5: During an erase, a read inside any selected sector (sector = top log2(NUM_SECT) address bits) returns the array byte with its top bit forced to 0.
- R6: A done pulse during an erase sets every byte of each selected, unprotected sector to all ones. Selected protected sectors and unselected sectors are left unchanged.
- R7: An erase in which every selected sector is protected shows R5 status for exactly ERASE_US*CLK_PER_US cycles, then ends with the array unchanged.
- R8: `suspend_req` during a running erase enters suspend, and reads inside selected sectors then show a top bit of 1. `resume_req` returns the erase to running, with a top bit of 0.
- R9: A program strobe while suspended follows the R2 and R3 rules at its address. Its done pulse returns the block to suspend. A program into a protected sector leaves the byte unchanged.
- R10: Reads of addresses not covered by an active status return array data. Start strobes received while busy are ignored, except a program strobe while suspended. An erase strobe with an empty mask is ignored.
- R11: `busy` rises on the clock edge that samples an accepted strobe and falls on the edge that ends the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Program strobe (final command write) |
| erase_start | input | 1 | Erase strobe |
| suspend_req | input | 1 | Suspend a running erase |
| resume_req | input | 1 | Resume a suspended erase |
| op_done | input | 1 | Internal timer done for the current unprotected operation |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | DATA_W | Byte to program |
| erase_sel | input | NUM_SECT | Sectors selected for erase |
| sect_prot | input | NUM_SECT | Per-sector protect map |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data or status (combinational) |
| busy | output | 1 | An internal operation is in progress |

## Verification
If the sequencer is left in the wrong state, status shows up at addresses it should not cover, or it is missing from ones it should. The bench sees this on the first read after the strobe or after the done pulse. If the protect window counter is off by one, `rd_data` and `busy` change one cycle early or late at the window's boundary, and the bench samples exactly there. A bad array update, such as a lost AND, an erased protected sector, or a write from a protected program, shows only when the bench reads that byte later. The bench keeps its own model of the array and compares every byte it reads against it.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_PROG_LOCK,
      ST_ERASE,
      ST_ERASE_LOCK,
      ST_SUSP,
      ST_SUSP_PROG
   } fp_state_e;
endpackage

// File: rtl/flash_poll_seq.sv
module flash_poll_seq
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int NUM_SECT  = 4,
   parameter int PROG_CYC  = 100,
   parameter int ERASE_CYC = 5000,
   parameter int CNT_W     = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_start,
   input  logic                erase_start,
   input  logic                suspend_req,
   input  logic                resume_req,
   input  logic                op_done,
   input  logic [ADDR_W-1:0]   cmd_addr,
   input  logic [DATA_W-1:0]   cmd_data,
   input  logic [NUM_SECT-1:0] erase_sel,
   input  logic [NUM_SECT-1:0] sect_prot,
   output fp_state_e           state,
   output logic [ADDR_W-1:0]   op_addr,
   output logic [DATA_W-1:0]   op_data,
   output logic [NUM_SECT-1:0] op_sel,
   output logic [NUM_SECT-1:0] erase_mask,
   output logic                commit_prog,
   output logic                commit_erase
);
   localparam int SECT_BITS = $clog2(NUM_SECT);

   logic [SECT_BITS-1:0] tgt_sidx;
   logic                 tgt_prot;
   logic [NUM_SECT-1:0]  eff_sel;
   logic                 op_lock;
   logic [CNT_W-1:0]     cnt;

   assign tgt_sidx = cmd_addr[ADDR_W-1 -: SECT_BITS];
   assign tgt_prot = sect_prot[tgt_sidx];
   assign eff_sel  = erase_sel & ~sect_prot;

   always_comb begin
      commit_prog  = op_done && ((state == ST_PROG) ||
                                 (state == ST_SUSP_PROG && !op_lock));
      commit_erase = op_done && (state == ST_ERASE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         op_addr    <= '0;
         op_data    <= '0;
         op_sel     <= '0;
         erase_mask <= '0;
         op_lock    <= 1'b0;
         cnt        <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (prog_start) begin
                  op_addr <= cmd_addr;
                  op_data <= cmd_data;
                  op_lock <= tgt_prot;
                  if (tgt_prot) begin
                     state <= ST_PROG_LOCK;
                     cnt   <= CNT_W'(PROG_CYC - 1);
                  end else begin
                     state <= ST_PROG;
                  end
               end else if (erase_start && |erase_sel) begin
                  op_sel     <= erase_sel;
                  erase_mask <= eff_sel;
                  if (eff_sel == '0) begin
                     state <= ST_ERASE_LOCK;
                     cnt   <= CNT_W'(ERASE_CYC - 1);
                  end else begin
                     state <= ST_ERASE;
                  end
               end
            end
            ST_PROG:
               if (op_done) state <= ST_IDLE;
            ST_PROG_LOCK, ST_ERASE_LOCK:
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            ST_ERASE:
               if (op_done)          state <= ST_IDLE;
               else if (suspend_req) state <= ST_SUSP;
            ST_SUSP: begin
               if (prog_start) begin
                  op_addr <= cmd_addr;
                  op_data <= cmd_data;
                  op_lock <= tgt_prot;
                  state   <= ST_SUSP_PROG;
               end else if (resume_req) begin
                  state <= ST_ERASE;
               end
            end
            ST_SUSP_PROG:
               if (op_done) state <= ST_SUSP;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_poll_array.sv
module flash_poll_array #(
   parameter int ADDR_W        = 7,
   parameter int DATA_W        = 8,
   parameter int NUM_SECT      = 4,
   parameter bit PROG_AND_ONLY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit_prog,
   input  logic [ADDR_W-1:0]   prog_addr,
   input  logic [DATA_W-1:0]   prog_data,
   input  logic                commit_erase,
   input  logic [NUM_SECT-1:0] erase_mask,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_q
);
   localparam int DEPTH     = 2 ** ADDR_W;
   localparam int SECT_BITS = $clog2(NUM_SECT);
   localparam int SH        = ADDR_W - SECT_BITS;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] new_byte;

   generate
      if (PROG_AND_ONLY) begin : g_and_rule
         assign new_byte = mem[prog_addr] & prog_data;
      end else begin : g_overwrite
         assign new_byte = prog_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
         if (commit_erase) begin
            for (int i = 0; i < DEPTH; i++)
               if (erase_mask[SECT_BITS'(i >> SH)]) mem[i] <= '1;
         end
         if (commit_prog) mem[prog_addr] <= new_byte;
      end
   end

   assign rd_q = mem[rd_addr];
endmodule

// File: rtl/flash_poll_rdmux.sv
module flash_poll_rdmux
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int NUM_SECT = 4
) (
   input  fp_state_e           state,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic [ADDR_W-1:0]   op_addr,
   input  logic [DATA_W-1:0]   op_data,
   input  logic [NUM_SECT-1:0] op_sel,
   input  logic [DATA_W-1:0]   mem_q,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int SECT_BITS = $clog2(NUM_SECT);
   localparam int MSB       = DATA_W - 1;

   logic [SECT_BITS-1:0] rd_sidx;
   logic                 prog_hit;
   logic                 in_sel;

   assign rd_sidx  = rd_addr[ADDR_W-1 -: SECT_BITS];
   assign in_sel   = op_sel[rd_sidx];
   assign prog_hit = (state inside {ST_PROG, ST_PROG_LOCK, ST_SUSP_PROG}) &&
                     (rd_addr == op_addr);

   always_comb begin
      rd_data = mem_q;
      if (prog_hit)
         rd_data[MSB] = ~op_data[MSB];
      else if (in_sel && (state inside {ST_ERASE, ST_ERASE_LOCK}))
         rd_data[MSB] = 1'b0;
      else if (in_sel && (state inside {ST_SUSP, ST_SUSP_PROG}))
         rd_data[MSB] = 1'b1;
   end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W        = 7,
   parameter int DATA_W        = 8,
   parameter int NUM_SECT      = 4,
   parameter int CLK_PER_US    = 50,
   parameter int PROG_US       = 2,
   parameter int ERASE_US      = 100,
   parameter bit PROG_AND_ONLY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_start,
   input  logic                erase_start,
   input  logic                suspend_req,
   input  logic                resume_req,
   input  logic                op_done,
   input  logic [ADDR_W-1:0]   cmd_addr,
   input  logic [DATA_W-1:0]   cmd_data,
   input  logic [NUM_SECT-1:0] erase_sel,
   input  logic [NUM_SECT-1:0] sect_prot,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic                busy
);
   localparam int SECT_BITS = $clog2(NUM_SECT);
   localparam int PROG_CYC  = PROG_US * CLK_PER_US;
   localparam int ERASE_CYC = ERASE_US * CLK_PER_US;
   localparam int MAX_CYC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   generate
      if (NUM_SECT < 2 || (1 << SECT_BITS) != NUM_SECT) begin : g_bad_sect
         $error("NUM_SECT must be a power of two of at least 2");
      end
      if (ADDR_W <= SECT_BITS || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must exceed the sector bits and stay at most 12");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (CLK_PER_US < 1 || PROG_US < 1 || ERASE_US < 1) begin : g_bad_time
         $error("timing parameters must be positive");
      end
   endgenerate

   fp_state_e           st_w;
   logic [ADDR_W-1:0]   op_addr_w;
   logic [DATA_W-1:0]   op_data_w;
   logic [NUM_SECT-1:0] op_sel_w;
   logic [NUM_SECT-1:0] erase_mask_w;
   logic                commit_prog_w;
   logic                commit_erase_w;
   logic [DATA_W-1:0]   mem_q_w;

   flash_poll_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .prog_start(prog_start), .erase_start(erase_start),
      .suspend_req(suspend_req), .resume_req(resume_req), .op_done(op_done),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .erase_sel(erase_sel), .sect_prot(sect_prot),
      .state(st_w), .op_addr(op_addr_w), .op_data(op_data_w),
      .op_sel(op_sel_w), .erase_mask(erase_mask_w),
      .commit_prog(commit_prog_w), .commit_erase(commit_erase_w)
   );

   flash_poll_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT),
      .PROG_AND_ONLY(PROG_AND_ONLY)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .commit_prog(commit_prog_w), .prog_addr(op_addr_w), .prog_data(op_data_w),
      .commit_erase(commit_erase_w), .erase_mask(erase_mask_w),
      .rd_addr(rd_addr), .rd_q(mem_q_w)
   );

   flash_poll_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT)
   ) u_rdmux (
      .state(st_w), .rd_addr(rd_addr), .op_addr(op_addr_w),
      .op_data(op_data_w), .op_sel(op_sel_w), .mem_q(mem_q_w),
      .rd_data(rd_data)
   );

   assign busy = (st_w != ST_IDLE);
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int NUM_SECT  = 4,
   parameter int PROG_CYC  = 100,
   parameter int ERASE_CYC = 5000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                prog_start,
   input logic                op_done,
   input logic                busy,
   input fp_state_e           st,
   input logic [ADDR_W-1:0]   rd_addr,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_SECT-1:0] op_sel,
   input logic                commit_prog
);
   localparam int SECT_BITS = $clog2(NUM_SECT);

   int unsigned plock_cnt;
   int unsigned elock_cnt;
   logic        rd_in_sel;

   assign rd_in_sel = op_sel[rd_addr[ADDR_W-1 -: SECT_BITS]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plock_cnt <= 0;
         elock_cnt <= 0;
      end else begin
         plock_cnt <= (st == ST_PROG_LOCK)  ? plock_cnt + 1 : 0;
         elock_cnt <= (st == ST_ERASE_LOCK) ? elock_cnt + 1 : 0;
      end
   end

   a_r11_accept_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && prog_start) |=> busy);

   a_r11_release_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PROG && op_done) |=> !busy);

   a_r3_commit_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
      commit_prog |=> (st == ST_IDLE || st == ST_SUSP));

   a_r4_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PROG_LOCK) |-> (plock_cnt < PROG_CYC));

   a_r4_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PROG_LOCK && plock_cnt < PROG_CYC - 1) |=> (st == ST_PROG_LOCK));

   a_r7_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE_LOCK) |-> (elock_cnt < ERASE_CYC));

   a_r7_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE_LOCK && elock_cnt < ERASE_CYC - 1) |=> (st == ST_ERASE_LOCK));

   a_r5_erase_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE && rd_in_sel) |-> !rd_data[DATA_W-1]);

   a_r8_suspend_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SUSP && rd_in_sel) |-> rd_data[DATA_W-1]);
endmodule

bind flash_poll_status flash_poll_status_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT),
   .PROG_CYC(PROG_US * CLK_PER_US), .ERASE_CYC(ERASE_US * CLK_PER_US)
) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .op_done(op_done),
   .busy(busy), .st(st_w), .rd_addr(rd_addr), .rd_data(rd_data),
   .op_sel(op_sel_w), .commit_prog(commit_prog_w)
);

// File: tb/flash_poll_status_bench.sv
module flash_poll_status_bench;
   localparam int AW = 7;
   localparam int DW = 8;
   localparam int NS = 4;
   localparam int CPU = 2;
   localparam int PU = 2;
   localparam int EU = 100;
   localparam int PC = PU * CPU;
   localparam int EC = EU * CPU;
   localparam int DEPTH = 2 ** AW;

   localparam int M_IDLE = 0, M_PROG = 1, M_PLOCK = 2, M_ERASE = 3,
                  M_ELOCK = 4, M_SUSP = 5, M_SPROG = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prog_start = 1'b0, erase_start = 1'b0;
   logic suspend_req = 1'b0, resume_req = 1'b0, op_done = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic [NS-1:0] erase_sel = '0;
   logic [NS-1:0] sect_prot = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy;

   int n_chk = 0;
   int n_fail = 0;

   logic [DW-1:0] bm [DEPTH];
   int            mode = M_IDLE;
   logic [AW-1:0] b_addr = '0;
   logic [DW-1:0] b_data = '0;
   logic [NS-1:0] b_sel = '0;
   logic [NS-1:0] b_eff = '0;
   logic          b_lock = 1'b0;

   flash_poll_status #(
      .ADDR_W(AW), .DATA_W(DW), .NUM_SECT(NS),
      .CLK_PER_US(CPU), .PROG_US(PU), .ERASE_US(EU)
   ) u_flash_poll_status (
      .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
      .suspend_req(suspend_req), .resume_req(resume_req), .op_done(op_done),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .erase_sel(erase_sel),
      .sect_prot(sect_prot), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   always #10 clk = ~clk;

   function automatic logic [1:0] sec_of(logic [AW-1:0] a);
      return a[AW-1 -: 2];
   endfunction

   function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
      logic [DW-1:0] d;
      d = bm[a];
      if ((mode == M_PROG || mode == M_PLOCK || mode == M_SPROG) && a == b_addr)
         d[DW-1] = ~b_data[DW-1];
      else if (b_sel[sec_of(a)] && (mode == M_ERASE || mode == M_ELOCK))
         d[DW-1] = 1'b0;
      else if (b_sel[sec_of(a)] && (mode == M_SUSP || mode == M_SPROG))
         d[DW-1] = 1'b1;
      return d;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check_rd(input logic [AW-1:0] a, input string req);
      logic [DW-1:0] e;
      rd_addr = a;
      #1;
      e = exp_rd(a);
      n_chk++;
      if (rd_data !== e) begin
         n_fail++;
         $display("FAIL %s read addr=%h got=%h exp=%h", req, a, rd_data, e);
      end
   endtask

   task automatic check_busy(input logic e, input string req);
      #1;
      n_chk++;
      if (busy !== e) begin
         n_fail++;
         $display("FAIL %s busy got=%b exp=%b", req, busy, e);
      end
   endtask

   task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [NS-1:0] prot);
      cmd_addr = a; cmd_data = d; sect_prot = prot; prog_start = 1'b1;
      tick();
      prog_start = 1'b0;
      if (mode == M_IDLE) begin
         b_addr = a; b_data = d; b_lock = prot[sec_of(a)];
         mode = b_lock ? M_PLOCK : M_PROG;
      end else if (mode == M_SUSP) begin
         b_addr = a; b_data = d; b_lock = prot[sec_of(a)];
         mode = M_SPROG;
      end
   endtask

   task automatic do_erase(input logic [NS-1:0] sel, input logic [NS-1:0] prot);
      erase_sel = sel; sect_prot = prot; erase_start = 1'b1;
      tick();
      erase_start = 1'b0;
      if (mode == M_IDLE && sel != '0) begin
         b_sel = sel; b_eff = sel & ~prot;
         mode = (b_eff == '0) ? M_ELOCK : M_ERASE;
      end
   endtask

   task automatic do_done();
      op_done = 1'b1;
      tick();
      op_done = 1'b0;
      if (mode == M_PROG) begin
         bm[b_addr] = bm[b_addr] & b_data; mode = M_IDLE;
      end else if (mode == M_SPROG) begin
         if (!b_lock) bm[b_addr] = bm[b_addr] & b_data;
         mode = M_SUSP;
      end else if (mode == M_ERASE) begin
         for (int i = 0; i < DEPTH; i++)
            if (b_eff[sec_of(AW'(i))]) bm[i] = '1;
         mode = M_IDLE;
      end
   endtask

   task automatic do_suspend();
      suspend_req = 1'b1; tick(); suspend_req = 1'b0;
      if (mode == M_ERASE) mode = M_SUSP;
   endtask

   task automatic do_resume();
      resume_req = 1'b1; tick(); resume_req = 1'b0;
      if (mode == M_SUSP) mode = M_ERASE;
   endtask

   // strobe already issued; status is up now; walk to the window edge
   task automatic lock_window(input int cyc, input logic [AW-1:0] a, input string req);
      check_rd(a, req);
      for (int k = 0; k < cyc - 1; k++) tick();
      check_rd(a, req);
      check_busy(1'b1, req);
      tick();
      mode = M_IDLE;
      check_rd(a, req);
      check_busy(1'b0, req);
   endtask

   task automatic rnd_reads(input int n, input logic [AW-1:0] hot, input string req);
      for (int k = 0; k < n; k++) begin
         if ($urandom_range(1, 0) == 1) check_rd(hot, req);
         else check_rd(AW'($urandom_range(DEPTH - 1, 0)), req);
      end
      tick();
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < DEPTH; i++) bm[i] = '1;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check_busy(1'b0, "R1");
      check_rd(7'h00, "R1");
      check_rd(7'h7F, "R1");
      tick();

      // R2, R3, R10, R11: unprotected program
      do_prog(7'h05, 8'hA5, 4'b0000);
      check_busy(1'b1, "R11");
      check_rd(7'h05, "R2");
      check_rd(7'h06, "R10");
      tick();
      do_erase(4'b0001, 4'b0000);      // ignored while busy (R10)
      check_rd(7'h06, "R10");
      do_done();
      check_busy(1'b0, "R11");
      check_rd(7'h05, "R3");
      check_rd(7'h06, "R10");
      tick();
      do_prog(7'h05, 8'h0F, 4'b0000);  // stale lower bits, true top bit after
      check_rd(7'h05, "R2");
      do_done();
      check_rd(7'h05, "R3");
      tick();

      // R10: empty erase mask is ignored
      do_erase(4'b0000, 4'b0000);
      check_busy(1'b0, "R10");
      tick();

      // R4: protected program window
      do_prog(7'h25, 8'h00, 4'b0010);
      lock_window(PC, 7'h25, "R4");
      tick();

      // R5, R6: partial protection erase
      do_prog(7'h01, 8'h12, 4'b0000); do_done();
      do_prog(7'h21, 8'h34, 4'b0000); do_done();
      do_prog(7'h41, 8'h56, 4'b0000); do_done();
      do_erase(4'b0011, 4'b0010);
      check_rd(7'h01, "R5");
      check_rd(7'h21, "R5");
      check_rd(7'h41, "R10");
      tick();
      do_done();
      check_rd(7'h01, "R6");
      check_rd(7'h21, "R6");
      check_rd(7'h41, "R6");
      tick();

      // R8, R9: suspend, program during suspend, resume
      do_erase(4'b0100, 4'b0000);
      check_rd(7'h41, "R5");
      do_suspend();
      check_rd(7'h41, "R8");
      do_prog(7'h10, 8'h81, 4'b0000);
      check_rd(7'h10, "R9");
      check_rd(7'h41, "R8");
      tick();
      do_done();
      check_busy(1'b1, "R9");
      check_rd(7'h10, "R9");
      check_rd(7'h41, "R8");
      tick();
      do_prog(7'h30, 8'h00, 4'b0001 | 4'b0010); // protected target while suspended
      check_rd(7'h30, "R9");
      do_done();
      check_rd(7'h30, "R9");
      do_resume();
      check_rd(7'h41, "R8");
      do_done();
      check_rd(7'h41, "R6");
      check_busy(1'b0, "R11");
      tick();

      // R7: all selected sectors protected
      do_prog(7'h70, 8'h3C, 4'b0000); do_done();
      do_erase(4'b1000, 4'b1000);
      lock_window(EC, 7'h70, "R7");
      tick();

      // constrained random mix
      for (int it = 0; it < 40; it++) begin
         int kind;
         logic [NS-1:0] prot;
         logic [AW-1:0] a;
         kind = $urandom_range(4, 0);
         prot = NS'($urandom_range(15, 0));
         a = AW'($urandom_range(DEPTH - 1, 0));
         if (kind <= 2) begin
            do_prog(a, DW'($urandom_range(255, 0)), prot);
            if (mode == M_PLOCK) lock_window(PC, a, "R4");
            else begin
               rnd_reads(3, a, "R2");
               do_done();
               rnd_reads(2, a, "R3");
            end
         end else begin
            logic [NS-1:0] sel;
            sel = NS'($urandom_range(15, 1));
            if (kind == 4) prot = prot & ~sel;
            do_erase(sel, prot);
            if (mode == M_ELOCK) begin
               lock_window(EC, AW'({sec_of(a), 5'h00}) , "R7");
            end else begin
               rnd_reads(3, a, "R5");
               if (kind == 4) begin
                  do_suspend();
                  rnd_reads(2, a, "R8");
                  do_prog(a, DW'($urandom_range(255, 0)), prot);
                  rnd_reads(3, a, "R9");
                  do_done();
                  rnd_reads(2, a, "R9");
                  do_resume();
               end
               do_done();
               rnd_reads(3, a, "R6");
            end
         end
         check_busy(1'b0, "R11");
         tick();
      end

      summary();
      $finish;
   end
endmodule